// File: doc/BRIEF.md
# Vector distance accumulate datapath

A lane-parallel half-precision arithmetic pipeline that evaluates one step of a vector distance or similarity metric per cycle. Every lane holds an adder, a multiplier and a direct path from the adder result into both multiplier inputs. With that path, a squared-difference step for L2 distance and an absolute-difference step for L1 distance each run as a single operation. A plain multiply-accumulate covers dot products and the cosine metric on normalised data. No square root is ever applied to the L2 result, because only the ranking of distances matters.

The sequencer selects the operands upstream and presents them as two vectors, one element per lane. With each operation it also supplies an opcode, the absolute-value control bit and the index of a destination accumulator. Results are written into an eight-entry accumulator register file inside the block, so partial sums never travel back to memory. Each completed result also appears on an output stream, and any accumulator can be read through a combinational read port.

Top module: `vdist_datapath`

## Requirements
- R1: After reset every accumulator register reads 0x0000 in every lane and `out_valid` is low.
- R2: Opcode 0 (ADD) writes the lane sum src_a+src_b into the addressed accumulator, replacing its old value. When `in_m` is 1, bit 15 (the sign) of the sum is forced to 0.
- R3: Opcode 1 (MUL) writes the lane product src_a*src_b into the addressed accumulator, replacing its old value.
- R4: Opcode 2 (MAC) adds src_a*src_b to the addressed accumulator.
- R5: Opcode 3 (AMC) adds (src_a-src_b)*(src_a-src_b) to the addressed accumulator. The difference goes straight into both multiplier inputs, so the added term is never negative.
- R6: Opcode 4 (MAN) adds src_a-src_b to the addressed accumulator. With `in_m`=1 it adds the absolute difference |src_a-src_b| instead.
- R7: An operation presented with `in_valid` at clock edge k appears on `out_valid`/`out_idx`/`out_data` after edge k+3. Results come out in issue order, and the accumulator reads back the result from edge k+4 on.
- R8: Back-to-back accumulating operations to the same accumulator each use the result of the operation before them.
- R9: Lanes are independent. Each lane's result depends only on that lane's operands and that lane's accumulator element.
- R10: An operation changes only the accumulator it addresses. All other accumulators keep their values.
- R11: An input with exponent field (bits 14:10) equal to 0 is treated as zero.
- R12: Arithmetic is IEEE binary16 with round-toward-zero (2048+3 gives 2050), and a zero result is encoded as 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 3 | Opcode: 0 ADD, 1 MUL, 2 MAC, 3 AMC, 4 MAN (5-7 unused) |
| in_m | input | 1 | Absolute-value control for the adder result |
| in_idx | input | 3 | Destination accumulator index |
| in_a | input | LANES x 16 | First operand vector, lane l in bits [16l+15:16l] |
| in_b | input | LANES x 16 | Second operand vector |
| out_valid | output | 1 | Result present on the output stream |
| out_idx | output | 3 | Accumulator index of the result |
| out_data | output | LANES x 16 | Result vector written to that accumulator |
| rd_idx | input | 3 | Read port index |
| rd_data | output | LANES x 16 | Committed contents of accumulator rd_idx |

## Verification
Every result is due three edges after the edge that accepts its operation, and it becomes readable from the accumulator one edge later. The driver records the cycle number at which it presents each operation, and pushes the expected vector and due cycle into a scoreboard. The monitor samples on the falling edge and checks the value, index and exact arrival cycle of every output. Accumulator reads through the read port happen only after the pipeline has drained, and are checked against the bench's own model of every register.

// File: rtl/vdist_pkg.sv
package vdist_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_MUL = 3'd1,
        OP_MAC = 3'd2,
        OP_AMC = 3'd3,
        OP_MAN = 3'd4
    } op_e;

    localparam int FP_W = 16;

    // binary16 add, round toward zero, exponent-0 inputs flushed to zero
    function automatic logic [15:0] fp_add(input logic [15:0] a, input logic [15:0] b);
        logic [15:0] x;
        logic [15:0] y;
        logic [42:0] mx;
        logic [42:0] my;
        logic [43:0] s;
        logic [43:0] n;
        logic [5:0]  d;
        logic [5:0]  p;
        logic [15:0] r;
        int          ei;
        logic        az;
        logic        bz;
        az = (a[14:10] == 5'd0);
        bz = (b[14:10] == 5'd0);
        r  = 16'h0000;
        if (az && bz) begin
            r = 16'h0000;
        end else if (az) begin
            r = b;
        end else if (bz) begin
            r = a;
        end else begin
            if (a[14:0] >= b[14:0]) begin
                x = a;
                y = b;
            end else begin
                x = b;
                y = a;
            end
            d  = {1'b0, x[14:10]} - {1'b0, y[14:10]};
            mx = {1'b1, x[9:0], 32'b0};
            my = {1'b1, y[9:0], 32'b0} >> d;
            if (x[15] == y[15]) s = {1'b0, mx} + {1'b0, my};
            else                s = {1'b0, mx} - {1'b0, my};
            if (s != 44'd0) begin
                p = 6'd0;
                for (int i = 0; i < 44; i++) begin
                    if (s[i]) p = 6'(i);
                end
                ei = int'(x[14:10]) + int'(p) - 42;
                n  = s << (6'd43 - p);
                if (ei <= 0)       r = 16'h0000;
                else if (ei >= 31) r = {x[15], 5'h1f, 10'h000};
                else               r = {x[15], 5'(ei), n[42:33]};
            end
        end
        return r;
    endfunction

    // binary16 multiply, round toward zero, exponent-0 inputs flushed to zero
    function automatic logic [15:0] fp_mul(input logic [15:0] a, input logic [15:0] b);
        logic [21:0] prod;
        logic [9:0]  frac;
        logic [15:0] r;
        logic        sg;
        int          ei;
        r = 16'h0000;
        if (a[14:10] != 5'd0 && b[14:10] != 5'd0) begin
            sg   = a[15] ^ b[15];
            prod = 22'({1'b1, a[9:0]}) * 22'({1'b1, b[9:0]});
            ei   = int'(a[14:10]) + int'(b[14:10]) - 15 + (prod[21] ? 1 : 0);
            frac = prod[21] ? prod[20:11] : prod[19:10];
            if (ei <= 0)       r = 16'h0000;
            else if (ei >= 31) r = {sg, 5'h1f, 10'h000};
            else               r = {sg, 5'(ei), frac};
        end
        return r;
    endfunction

endpackage

// File: rtl/vdist_add_stage.sv
module vdist_add_stage
    import vdist_pkg::*;
#(
    parameter int LANES = 16,
    parameter int REGS  = 8,
    localparam int IW   = $clog2(REGS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [2:0]                  in_op,
    input  logic                        in_m,
    input  logic [IW-1:0]               in_idx,
    input  logic [LANES-1:0][FP_W-1:0]  in_a,
    input  logic [LANES-1:0][FP_W-1:0]  in_b,
    output logic                        s1_valid,
    output logic [2:0]                  s1_op,
    output logic [IW-1:0]               s1_idx,
    output logic [LANES-1:0][FP_W-1:0]  s1_x,
    output logic [LANES-1:0][FP_W-1:0]  s1_y
);

    typedef logic [LANES-1:0][FP_W-1:0] vec_t;

    typedef struct packed {
        logic          valid;
        logic [2:0]    op;
        logic [IW-1:0] idx;
        vec_t          x;
        vec_t          y;
    } st_t;

    st_t  st_d, st_q;
    vec_t add_res;
    logic use_add;
    logic negate_b;

    assign use_add  = (in_op == OP_ADD) || (in_op == OP_AMC) || (in_op == OP_MAN);
    assign negate_b = (in_op == OP_AMC) || (in_op == OP_MAN);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [FP_W-1:0] b_eff;
        logic [FP_W-1:0] sum;
        assign b_eff = {in_b[l][15] ^ negate_b, in_b[l][14:0]};
        assign sum   = fp_add(in_a[l], b_eff);
        assign add_res[l] = in_m ? {1'b0, sum[14:0]} : sum;

        AST_ABS_CLEARS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_m && use_add) |=> !s1_x[l][15]); // R6
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.op  = in_op;
            st_d.idx = in_idx;
            st_d.x   = use_add ? add_res : in_a;
            st_d.y   = in_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s1_valid = st_q.valid;
    assign s1_op    = st_q.op;
    assign s1_idx   = st_q.idx;
    assign s1_x     = st_q.x;
    assign s1_y     = st_q.y;

endmodule

// File: rtl/vdist_mul_stage.sv
module vdist_mul_stage
    import vdist_pkg::*;
#(
    parameter int LANES = 16,
    parameter int REGS  = 8,
    localparam int IW   = $clog2(REGS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        s1_valid,
    input  logic [2:0]                  s1_op,
    input  logic [IW-1:0]               s1_idx,
    input  logic [LANES-1:0][FP_W-1:0]  s1_x,
    input  logic [LANES-1:0][FP_W-1:0]  s1_y,
    output logic                        s2_valid,
    output logic [2:0]                  s2_op,
    output logic [IW-1:0]               s2_idx,
    output logic [LANES-1:0][FP_W-1:0]  s2_p
);

    typedef logic [LANES-1:0][FP_W-1:0] vec_t;

    typedef struct packed {
        logic          valid;
        logic [2:0]    op;
        logic [IW-1:0] idx;
        vec_t          p;
    } st_t;

    st_t  st_d, st_q;
    vec_t mul_res;
    logic square;
    logic bypass;

    assign square = (s1_op == OP_AMC);
    assign bypass = (s1_op == OP_ADD) || (s1_op == OP_MAN);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [FP_W-1:0] fb;
        assign fb         = square ? s1_x[l] : s1_y[l];
        assign mul_res[l] = fp_mul(s1_x[l], fb);

        AST_SQUARE_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
            (s1_valid && s1_op == OP_AMC) |=> !s2_p[l][15]); // R5
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = s1_valid;
        if (s1_valid) begin
            st_d.op  = s1_op;
            st_d.idx = s1_idx;
            st_d.p   = bypass ? s1_x : mul_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s2_valid = st_q.valid;
    assign s2_op    = st_q.op;
    assign s2_idx   = st_q.idx;
    assign s2_p     = st_q.p;

endmodule

// File: rtl/vdist_acc_stage.sv
module vdist_acc_stage
    import vdist_pkg::*;
#(
    parameter int LANES = 16,
    parameter int REGS  = 8,
    localparam int IW   = $clog2(REGS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        s2_valid,
    input  logic [2:0]                  s2_op,
    input  logic [IW-1:0]               s2_idx,
    input  logic [LANES-1:0][FP_W-1:0]  s2_p,
    output logic                        wb_valid,
    output logic [IW-1:0]               wb_idx,
    output logic [LANES-1:0][FP_W-1:0]  wb_data,
    input  logic [IW-1:0]               rd_idx,
    output logic [LANES-1:0][FP_W-1:0]  rd_data
);

    typedef logic [LANES-1:0][FP_W-1:0] vec_t;

    typedef struct packed {
        logic                wb_valid;
        logic [IW-1:0]       wb_idx;
        vec_t                wb_data;
        logic [REGS-1:0][LANES-1:0][FP_W-1:0] grf;
    } st_t;

    st_t  st_d, st_q;
    vec_t old_val;
    vec_t sum_res;
    logic accumulate;
    logic fwd_hit;

    assign accumulate = (s2_op == OP_MAC) || (s2_op == OP_AMC) || (s2_op == OP_MAN);
    // the pending write in wb is not yet in the file: forward it
    assign fwd_hit    = st_q.wb_valid && (st_q.wb_idx == s2_idx);
    assign old_val    = fwd_hit ? st_q.wb_data : st_q.grf[s2_idx];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign sum_res[l] = fp_add(old_val[l], s2_p[l]);
    end

    always_comb begin
        st_d = st_q;
        if (st_q.wb_valid) st_d.grf[st_q.wb_idx] = st_q.wb_data;
        st_d.wb_valid = s2_valid;
        if (s2_valid) begin
            st_d.wb_idx  = s2_idx;
            st_d.wb_data = accumulate ? sum_res : s2_p;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wb_valid = st_q.wb_valid;
    assign wb_idx   = st_q.wb_idx;
    assign wb_data  = st_q.wb_data;
    assign rd_data  = st_q.grf[rd_idx];

    AST_WB_FOLLOWS_MUL: assert property (@(posedge clk) disable iff (!rst_n)
        s2_valid |=> wb_valid); // R7
    AST_NO_SPURIOUS_WB: assert property (@(posedge clk) disable iff (!rst_n)
        !s2_valid |=> !wb_valid); // R7

    for (genvar r = 0; r < REGS; r++) begin : g_reg
        AST_OTHER_REGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            !(st_q.wb_valid && st_q.wb_idx == IW'(r)) |=> $stable(st_q.grf[r])); // R10
    end

endmodule

// File: rtl/vdist_datapath.sv
module vdist_datapath
    import vdist_pkg::*;
#(
    parameter int LANES = 16,
    parameter int REGS  = 8,
    localparam int IW   = $clog2(REGS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [2:0]                  in_op,
    input  logic                        in_m,
    input  logic [IW-1:0]               in_idx,
    input  logic [LANES-1:0][FP_W-1:0]  in_a,
    input  logic [LANES-1:0][FP_W-1:0]  in_b,
    output logic                        out_valid,
    output logic [IW-1:0]               out_idx,
    output logic [LANES-1:0][FP_W-1:0]  out_data,
    input  logic [IW-1:0]               rd_idx,
    output logic [LANES-1:0][FP_W-1:0]  rd_data
);

    logic                       s1_valid;
    logic [2:0]                 s1_op;
    logic [IW-1:0]              s1_idx;
    logic [LANES-1:0][FP_W-1:0] s1_x;
    logic [LANES-1:0][FP_W-1:0] s1_y;
    logic                       s2_valid;
    logic [2:0]                 s2_op;
    logic [IW-1:0]              s2_idx;
    logic [LANES-1:0][FP_W-1:0] s2_p;

    vdist_add_stage #(.LANES(LANES), .REGS(REGS)) u_add (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_op(in_op), .in_m(in_m), .in_idx(in_idx),
        .in_a(in_a), .in_b(in_b),
        .s1_valid(s1_valid), .s1_op(s1_op), .s1_idx(s1_idx), .s1_x(s1_x), .s1_y(s1_y)
    );

    vdist_mul_stage #(.LANES(LANES), .REGS(REGS)) u_mul (
        .clk(clk), .rst_n(rst_n),
        .s1_valid(s1_valid), .s1_op(s1_op), .s1_idx(s1_idx), .s1_x(s1_x), .s1_y(s1_y),
        .s2_valid(s2_valid), .s2_op(s2_op), .s2_idx(s2_idx), .s2_p(s2_p)
    );

    vdist_acc_stage #(.LANES(LANES), .REGS(REGS)) u_acc (
        .clk(clk), .rst_n(rst_n),
        .s2_valid(s2_valid), .s2_op(s2_op), .s2_idx(s2_idx), .s2_p(s2_p),
        .wb_valid(out_valid), .wb_idx(out_idx), .wb_data(out_data),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 3)); // R7
    AST_IDX_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_idx == $past(in_idx, 3)); // R7

endmodule

// File: tb/sim_vdist_datapath.sv
module sim_vdist_datapath;

    localparam int LANES = 16;
    localparam int REGS  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [2:0] in_op = 3'd0;
    logic in_m = 1'b0;
    logic [2:0] in_idx = 3'd0;
    logic [LANES-1:0][15:0] in_a = '0;
    logic [LANES-1:0][15:0] in_b = '0;
    logic out_valid;
    logic [2:0] out_idx;
    logic [LANES-1:0][15:0] out_data;
    logic [2:0] rd_idx = 3'd0;
    logic [LANES-1:0][15:0] rd_data;

    vdist_datapath #(.LANES(LANES), .REGS(REGS)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_m(in_m),
        .in_idx(in_idx), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_idx(out_idx), .out_data(out_data), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int model [REGS][LANES];
    int va [LANES];
    int vb [LANES];

    typedef struct packed {
        int                     due;
        logic [2:0]             idx;
        logic [LANES-1:0][15:0] data;
    } item_t;
    item_t sb_q[$];
    string tag_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int msb(int m);
        int p = 0;
        for (int i = 0; i < 31; i++) if (m[i]) p = i;
        return p;
    endfunction

    function automatic int rtz(int n);
        int m = (n < 0) ? -n : n;
        int p;
        if (m < 2048) return n;
        p = msb(m);
        m = (m >> (p - 10)) << (p - 10);
        return (n < 0) ? -m : m;
    endfunction

    function automatic logic [15:0] enc(int n);
        int m = (n < 0) ? -n : n;
        int p;
        int f;
        if (m == 0) return 16'h0000;
        p = msb(m);
        f = (p >= 10) ? (m >> (p - 10)) : (m << (10 - p));
        return {(n < 0), 5'(p + 15), f[9:0]};
    endfunction

    function automatic int iabs(int n);
        return (n < 0) ? -n : n;
    endfunction

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic issue_raw(input int op, input logic m, input int idx,
                             input logic [LANES-1:0][15:0] ea,
                             input logic [LANES-1:0][15:0] eb, input string tag);
        item_t it;
        int r;
        int d;
        @(negedge clk);
        for (int l = 0; l < LANES; l++) begin
            case (op)
                0: begin r = rtz(va[l] + vb[l]); if (m) r = iabs(r); end
                1: r = rtz(va[l] * vb[l]);
                2: r = rtz(model[idx][l] + rtz(va[l] * vb[l]));
                3: begin d = rtz(va[l] - vb[l]); r = rtz(model[idx][l] + rtz(d * d)); end
                default: begin
                    d = rtz(va[l] - vb[l]);
                    if (m) d = iabs(d);
                    r = rtz(model[idx][l] + d);
                end
            endcase
            model[idx][l] = r;
            it.data[l] = enc(r);
        end
        it.idx = 3'(idx);
        it.due = cyc + 3;
        sb_q.push_back(it);
        tag_q.push_back(tag);
        in_valid = 1'b1;
        in_op = 3'(op);
        in_m = m;
        in_idx = 3'(idx);
        in_a = ea;
        in_b = eb;
    endtask

    task automatic issue(input int op, input logic m, input int idx, input string tag);
        logic [LANES-1:0][15:0] ea;
        logic [LANES-1:0][15:0] eb;
        for (int l = 0; l < LANES; l++) begin
            ea[l] = enc(va[l]);
            eb[l] = enc(vb[l]);
        end
        issue_raw(op, m, idx, ea, eb, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: scoreboard comparison of the output stream
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R7", "unexpected output", 32'(out_idx), 32'hffff_ffff);
            end else begin
                item_t it;
                string tg;
                it = sb_q.pop_front();
                tg = tag_q.pop_front();
                check(cyc == it.due, "R7", "arrival cycle", 32'(cyc), 32'(it.due));
                check(out_idx == it.idx, tg, "index", 32'(out_idx), 32'(it.idx));
                for (int l = 0; l < LANES; l++) begin
                    if (out_data[l] !== it.data[l]) begin
                        check(1'b0, tg, $sformatf("lane %0d", l), 32'(out_data[l]), 32'(it.data[l]));
                        break;
                    end
                end
                check(out_data === it.data, tg, "vector", out_data[0], it.data[0]);
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : driver
        logic [LANES-1:0][15:0] ea;
        logic [LANES-1:0][15:0] eb;
        for (int r = 0; r < REGS; r++) for (int l = 0; l < LANES; l++) model[r][l] = 0;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int r = 0; r < REGS; r++) begin
            rd_idx = 3'(r);
            #1;
            check(rd_data === '0, "R1", $sformatf("reg %0d after reset", r), rd_data[0], 32'd0);
        end

        // R2 / R9: plain add, per-lane distinct values, with and without sign clear
        for (int l = 0; l < LANES; l++) begin va[l] = l + 1; vb[l] = 2 * l - 20; end
        issue(0, 1'b0, 0, "R2 R9");
        issue(0, 1'b1, 1, "R2 abs");
        // R3: multiply overwrites
        for (int l = 0; l < LANES; l++) begin va[l] = l - 3; vb[l] = 3; end
        issue(1, 1'b0, 2, "R3");
        // R4 / R8: back-to-back multiply-accumulate into one register
        for (int l = 0; l < LANES; l++) begin va[l] = l - 7; vb[l] = 5; end
        issue(2, 1'b0, 3, "R4");
        for (int l = 0; l < LANES; l++) begin va[l] = 2; vb[l] = l; end
        issue(2, 1'b0, 3, "R8 mac fwd");
        // R5 / R8: three back-to-back squared differences
        for (int l = 0; l < LANES; l++) begin va[l] = l; vb[l] = 5; end
        issue(3, 1'b0, 4, "R5");
        for (int l = 0; l < LANES; l++) begin va[l] = 1; vb[l] = l; end
        issue(3, 1'b0, 4, "R5 R8");
        issue(3, 1'b1, 4, "R5 R8 m");
        // R6: absolute and signed difference accumulation
        for (int l = 0; l < LANES; l++) begin va[l] = 4; vb[l] = l; end
        issue(4, 1'b1, 5, "R6 abs");
        issue(4, 1'b1, 5, "R6 R8");
        issue(4, 1'b0, 5, "R6 signed");
        idle(1);
        // R7: interleaved destinations, order and index carry
        for (int l = 0; l < LANES; l++) begin va[l] = l; vb[l] = 1; end
        issue(2, 1'b0, 3, "R7");
        issue(4, 1'b1, 5, "R7");
        issue(2, 1'b0, 3, "R7 R8");
        idle(2);
        // R11: exponent-0 inputs act as zero
        for (int l = 0; l < LANES; l++) begin
            va[l] = 0; vb[l] = l + 5;
            ea[l] = 16'(l + 1);
            eb[l] = enc(vb[l]);
        end
        issue_raw(0, 1'b0, 6, ea, eb, "R11 add");
        for (int l = 0; l < LANES; l++) begin
            vb[l] = 2; ea[l] = 16'h03ff; eb[l] = enc(2);
        end
        issue_raw(1, 1'b0, 6, ea, eb, "R11 mul");
        // R12: truncation toward zero, and zero encoding
        for (int l = 0; l < LANES; l++) begin va[l] = (l < 8) ? 2048 : -2048; vb[l] = (l < 8) ? l : -l; end
        issue(0, 1'b0, 7, "R12");
        for (int l = 0; l < LANES; l++) begin va[l] = l; vb[l] = -l; end
        issue(0, 1'b0, 0, "R12 zero");
        idle(8);

        // R10 / R7: committed contents of every accumulator via read port
        for (int r = 0; r < REGS; r++) begin
            logic [LANES-1:0][15:0] ev;
            for (int l = 0; l < LANES; l++) ev[l] = enc(model[r][l]);
            rd_idx = 3'(r);
            #1;
            check(rd_data === ev, "R10", $sformatf("reg %0d readback", r), rd_data[0], ev[0]);
        end
        check(sb_q.size() == 0, "R7", "pending results", 32'(sb_q.size()), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule